// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Carry

This block is the arithmetic and register core of a small nibble-wide processor. It holds an accumulator, a carry flag, a scratch register, a byte register and a short page pointer. Each clock cycle it executes one operation chosen by an opcode input. The operations are additions, logic operations, a rotate through carry, carry set and clear, and register transfers. The second operand comes from a memory operand input or from an immediate input.

Instruction fetch, program counter sequencing and data memory addressing sit outside the block. The surrounding sequencer drives the opcode, the immediate and the memory operand, and reads back the register contents. It also reads two further outputs: a table address made from the page pointer and the accumulator, and a one-cycle skip indication raised by the add-immediate operation.

Top module: `nib_acc_core`

## Requirements
- R1: While reset is low, and after it is released, the accumulator, carry, scratch register, byte register, page pointer and skip output all read 0.
- R2: Opcode 4'h1 (add with carry) writes the low nibble of accumulator + memory operand + carry into the accumulator. It sets the carry to 1 if the sum overflows the nibble and clears it to 0 otherwise.
- R3: Opcode 4'h2 (add memory) writes the low nibble of accumulator + memory operand into the accumulator and leaves the carry unchanged.
- R4: Opcode 4'h3 (add immediate) writes the low nibble of accumulator + immediate into the accumulator and leaves the carry unchanged. The skip output is 1 for the one cycle after the operation exactly when the sum overflowed. In every other cycle it is 0.
- R5: Opcode 4'h4 writes accumulator AND memory operand into the accumulator, and opcode 4'h5 writes accumulator OR memory operand into the accumulator. Both leave the carry unchanged.
- R6: Opcode 4'h6 rotates right through carry. Accumulator bit 0 goes into the carry, the old carry goes into the accumulator's top bit, and the other bits shift down by one.
- R7: Opcode 4'h7 sets the carry to 1 and opcode 4'h8 clears it to 0. Neither changes the accumulator.
- R8: Opcode 4'h9 copies the accumulator into the scratch register, and opcode 4'hA copies the scratch register into the accumulator.
- R9: Opcode 4'hB loads the byte register with the scratch register in the high nibble and the accumulator in the low nibble. Opcode 4'hC does the reverse: the byte register's high nibble goes to the scratch register and its low nibble goes to the accumulator.
- R10: Opcode 4'hE loads the accumulator from the immediate. Opcode 4'hD loads the page pointer from the low 3 bits of the immediate.
- R11: The table address output is the page pointer in bits 6..4 and the accumulator in bits 3..0. It follows both registers in the same cycle they change.
- R12: Opcodes 4'h0 and 4'hF change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode executed at the next rising edge |
| imm_i | input | 4 | Immediate operand |
| mem_i | input | 4 | Memory operand |
| acc_o | output | 4 | Accumulator |
| cy_o | output | 1 | Carry flag |
| b_o | output | 4 | Scratch register |
| e_o | output | 8 | Byte register |
| d_o | output | 3 | Page pointer |
| tab_addr_o | output | 7 | In-page table address |
| skip_o | output | 1 | One-cycle skip indication from add immediate |

## Verification
Every register, the carry and the skip flag take their new value at the rising edge that executes the opcode. They are therefore due one cycle after the opcode is applied. The table address is combinational on the registers, so it is due in that same cycle. The bench drives each opcode at a falling edge and samples two time units after the following rising edge. Each result is read in the cycle it becomes valid, before the next opcode can disturb it. The skip output is checked both in the cycle after an overflowing add immediate and in the cycle after a non-overflowing one, to confirm it lasts exactly one cycle.

// File: rtl/nib_acc_pkg.sv
package nib_acc_pkg;

   typedef enum logic [3:0] {
      OP_NOP  = 4'h0,
      OP_ADC  = 4'h1,
      OP_ADDM = 4'h2,
      OP_ADDI = 4'h3,
      OP_AND  = 4'h4,
      OP_OR   = 4'h5,
      OP_RAR  = 4'h6,
      OP_SETC = 4'h7,
      OP_CLRC = 4'h8,
      OP_A2B  = 4'h9,
      OP_B2A  = 4'hA,
      OP_BA2E = 4'hB,
      OP_E2BA = 4'hC,
      OP_LDD  = 4'hD,
      OP_LDI  = 4'hE,
      OP_RSV  = 4'hF
   } acc_op_e;

   function automatic logic op_writes_carry(acc_op_e op);
      return (op == OP_ADC) || (op == OP_RAR) || (op == OP_SETC) || (op == OP_CLRC);
   endfunction

endpackage

// File: rtl/nib_alu.sv
module nib_alu
   import nib_acc_pkg::*;
#(
   parameter int DW         = 4,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  acc_op_e        op,
   input  logic [DW-1:0]  a,
   input  logic [DW-1:0]  m,
   input  logic [DW-1:0]  imm,
   input  logic           cy,
   output logic [DW-1:0]  a_nxt,
   output logic           a_we,
   output logic           cy_nxt,
   output logic           cy_we,
   output logic           skip_nxt
);

   logic [DW-1:0] opnd;
   logic          cin;
   logic [DW-1:0] sum;
   logic          cout;

   assign opnd = (op == OP_ADDI) ? imm : m;
   assign cin  = (op == OP_ADC) ? cy : 1'b0;

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [DW:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign sum[i]   = a[i] ^ opnd[i] ^ c[i];
            assign c[i+1]   = (a[i] & opnd[i]) | (c[i] & (a[i] ^ opnd[i]));
         end
         assign cout = c[DW];
      end else begin : g_behav
         logic [DW:0] wide;
         assign wide = {1'b0, a} + {1'b0, opnd} + {{DW{1'b0}}, cin};
         assign sum  = wide[DW-1:0];
         assign cout = wide[DW];
      end
   endgenerate

   always_comb begin
      a_nxt    = a;
      a_we     = 1'b0;
      cy_nxt   = cy;
      skip_nxt = 1'b0;
      unique case (op)
         OP_ADC: begin
            a_nxt  = sum;
            a_we   = 1'b1;
            cy_nxt = cout;
         end
         OP_ADDM: begin
            a_nxt = sum;
            a_we  = 1'b1;
         end
         OP_ADDI: begin
            a_nxt    = sum;
            a_we     = 1'b1;
            skip_nxt = cout;
         end
         OP_AND: begin
            a_nxt = a & m;
            a_we  = 1'b1;
         end
         OP_OR: begin
            a_nxt = a | m;
            a_we  = 1'b1;
         end
         OP_RAR: begin
            a_nxt  = {cy, a[DW-1:1]};
            a_we   = 1'b1;
            cy_nxt = a[0];
         end
         OP_SETC: cy_nxt = 1'b1;
         OP_CLRC: cy_nxt = 1'b0;
         default: ;
      endcase
   end

   assign cy_we = op_writes_carry(op);

endmodule

// File: rtl/nib_xfer.sv
module nib_xfer
   import nib_acc_pkg::*;
#(
   parameter int DW = 4,
   parameter int PW = 3,
   localparam int EW = 2 * DW
) (
   input  acc_op_e        op,
   input  logic [DW-1:0]  a,
   input  logic [DW-1:0]  b,
   input  logic [EW-1:0]  e,
   input  logic [DW-1:0]  imm,
   output logic [DW-1:0]  a_nxt,
   output logic           a_we,
   output logic [DW-1:0]  b_nxt,
   output logic           b_we,
   output logic [EW-1:0]  e_nxt,
   output logic           e_we,
   output logic [PW-1:0]  d_nxt,
   output logic           d_we
);

   always_comb begin
      a_nxt = a;
      a_we  = 1'b0;
      b_nxt = b;
      b_we  = 1'b0;
      e_nxt = e;
      e_we  = 1'b0;
      d_nxt = imm[PW-1:0];
      d_we  = 1'b0;
      unique case (op)
         OP_A2B: begin
            b_nxt = a;
            b_we  = 1'b1;
         end
         OP_B2A: begin
            a_nxt = b;
            a_we  = 1'b1;
         end
         OP_BA2E: begin
            e_nxt = {b, a};
            e_we  = 1'b1;
         end
         OP_E2BA: begin
            b_nxt = e[EW-1:DW];
            a_nxt = e[DW-1:0];
            a_we  = 1'b1;
            b_we  = 1'b1;
         end
         OP_LDI: begin
            a_nxt = imm;
            a_we  = 1'b1;
         end
         OP_LDD: d_we = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/nib_acc_core.sv
module nib_acc_core
   import nib_acc_pkg::*;
#(
   parameter int DW         = 4,
   parameter int PW         = 3,
   parameter bit RIPPLE_ADD = 1'b1,
   localparam int EW        = 2 * DW,
   localparam int TW        = PW + DW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [3:0]     op_i,
   input  logic [DW-1:0]  imm_i,
   input  logic [DW-1:0]  mem_i,
   output logic [DW-1:0]  acc_o,
   output logic           cy_o,
   output logic [DW-1:0]  b_o,
   output logic [EW-1:0]  e_o,
   output logic [PW-1:0]  d_o,
   output logic [TW-1:0]  tab_addr_o,
   output logic           skip_o
);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("nib_acc_core: DW must be at least 2");
      end
      if (PW < 1 || PW > DW) begin : g_bad_pw
         $error("nib_acc_core: PW must lie in 1..DW");
      end
   endgenerate

   acc_op_e op;
   assign op = acc_op_e'(op_i);

   logic [DW-1:0] a_q, b_q;
   logic [EW-1:0] e_q;
   logic [PW-1:0] d_q;
   logic          cy_q, skip_q;

   logic [DW-1:0] alu_a_nxt;
   logic          alu_a_we, alu_cy_nxt, alu_cy_we, alu_skip;
   logic [DW-1:0] x_a_nxt, x_b_nxt;
   logic          x_a_we, x_b_we, x_e_we, x_d_we;
   logic [EW-1:0] x_e_nxt;
   logic [PW-1:0] x_d_nxt;

   nib_alu #(.DW(DW), .RIPPLE_ADD(RIPPLE_ADD)) u_alu (
      .op       (op),
      .a        (a_q),
      .m        (mem_i),
      .imm      (imm_i),
      .cy       (cy_q),
      .a_nxt    (alu_a_nxt),
      .a_we     (alu_a_we),
      .cy_nxt   (alu_cy_nxt),
      .cy_we    (alu_cy_we),
      .skip_nxt (alu_skip)
   );

   nib_xfer #(.DW(DW), .PW(PW)) u_xfer (
      .op    (op),
      .a     (a_q),
      .b     (b_q),
      .e     (e_q),
      .imm   (imm_i),
      .a_nxt (x_a_nxt),
      .a_we  (x_a_we),
      .b_nxt (x_b_nxt),
      .b_we  (x_b_we),
      .e_nxt (x_e_nxt),
      .e_we  (x_e_we),
      .d_nxt (x_d_nxt),
      .d_we  (x_d_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         e_q    <= '0;
         d_q    <= '0;
         cy_q   <= 1'b0;
         skip_q <= 1'b0;
      end else begin
         if (alu_a_we)     a_q <= alu_a_nxt;
         else if (x_a_we)  a_q <= x_a_nxt;
         if (x_b_we)       b_q <= x_b_nxt;
         if (x_e_we)       e_q <= x_e_nxt;
         if (x_d_we)       d_q <= x_d_nxt;
         if (alu_cy_we)    cy_q <= alu_cy_nxt;
         skip_q <= alu_skip;
      end
   end

   assign acc_o      = a_q;
   assign cy_o       = cy_q;
   assign b_o        = b_q;
   assign e_o        = e_q;
   assign d_o        = d_q;
   assign skip_o     = skip_q;
   assign tab_addr_o = {d_q, a_q};

endmodule

// File: rtl/nib_acc_chk.sv
module nib_acc_chk
   import nib_acc_pkg::*;
#(
   parameter int DW = 4,
   parameter int PW = 3,
   localparam int EW = 2 * DW
) (
   input logic           clk,
   input logic           rst_n,
   input logic [3:0]     op_i,
   input logic [DW-1:0]  imm_i,
   input logic [DW-1:0]  mem_i,
   input logic [DW-1:0]  acc_o,
   input logic           cy_o,
   input logic [DW-1:0]  b_o,
   input logic [EW-1:0]  e_o,
   input logic [PW-1:0]  d_o,
   input logic           skip_o,
   input logic           alu_a_we,
   input logic           x_a_we
);

   AST_ADC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_ADC) |-> ({cy_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(mem_i)} + {{DW{1'b0}}, $past(cy_o)}))); // R2

   AST_ADDM_CY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_ADDM) |-> (cy_o == $past(cy_o) && acc_o == DW'($past(acc_o) + $past(mem_i)))); // R3

   AST_SKIP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> ($past(op_i) == OP_ADDI)); // R4

   AST_ADDI_CY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_ADDI) |-> (cy_o == $past(cy_o))); // R4

   AST_LOGIC_CY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_AND || $past(op_i) == OP_OR) |-> $stable(cy_o)); // R5

   AST_RAR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_RAR) |-> (cy_o == $past(acc_o[0]) && acc_o[DW-1] == $past(cy_o))); // R6

   AST_SETC_CLRC: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_SETC || $past(op_i) == OP_CLRC) |-> (cy_o == ($past(op_i) == OP_SETC) && $stable(acc_o))); // R7

   AST_A2B_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_A2B) |-> (b_o == $past(acc_o))); // R8

   AST_E2BA_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_E2BA) |-> ({b_o, acc_o} == $past(e_o))); // R9

   AST_LOAD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_LDI) |-> (acc_o == $past(imm_i))); // R10

   AST_LOAD_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_LDD) |-> (d_o == $past(imm_i[PW-1:0]))); // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_i) == OP_NOP || $past(op_i) == OP_RSV) |-> ($stable(acc_o) && $stable(cy_o) && $stable(b_o) && $stable(e_o) && $stable(d_o))); // R12

   AST_ONE_A_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({alu_a_we, x_a_we})); // R2

endmodule

bind nib_acc_core nib_acc_chk #(.DW(DW), .PW(PW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .imm_i    (imm_i),
   .mem_i    (mem_i),
   .acc_o    (acc_o),
   .cy_o     (cy_o),
   .b_o      (b_o),
   .e_o      (e_o),
   .d_o      (d_o),
   .skip_o   (skip_o),
   .alu_a_we (alu_a_we),
   .x_a_we   (x_a_we)
);

// File: tb/sim_nib_acc_core.sv
module sim_nib_acc_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = 4'h0;
   logic [3:0] imm_i = 4'h0;
   logic [3:0] mem_i = 4'h0;
   logic [3:0] acc_o, b_o;
   logic       cy_o, skip_o;
   logic [7:0] e_o;
   logic [2:0] d_o;
   logic [6:0] tab_addr_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   nib_acc_core u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op_i),
      .imm_i      (imm_i),
      .mem_i      (mem_i),
      .acc_o      (acc_o),
      .cy_o       (cy_o),
      .b_o        (b_o),
      .e_o        (e_o),
      .d_o        (d_o),
      .tab_addr_o (tab_addr_o),
      .skip_o     (skip_o)
   );

   // {op, imm, mem, expected acc, expected carry, expected skip}
   localparam int NV = 18;
   localparam logic [17:0] VEC [NV] = '{
      {4'hE, 4'h9, 4'h0, 4'h9, 1'b0, 1'b0},
      {4'h1, 4'h0, 4'h8, 4'h1, 1'b1, 1'b0},
      {4'h1, 4'h0, 4'h2, 4'h4, 1'b0, 1'b0},
      {4'h7, 4'h0, 4'h0, 4'h4, 1'b1, 1'b0},
      {4'h2, 4'h0, 4'hF, 4'h3, 1'b1, 1'b0},
      {4'h3, 4'hE, 4'h0, 4'h1, 1'b1, 1'b1},
      {4'h3, 4'h2, 4'h0, 4'h3, 1'b1, 1'b0},
      {4'h8, 4'h0, 4'h0, 4'h3, 1'b0, 1'b0},
      {4'h3, 4'hF, 4'h0, 4'h2, 1'b0, 1'b1},
      {4'h5, 4'h0, 4'hC, 4'hE, 1'b0, 1'b0},
      {4'h4, 4'h0, 4'h6, 4'h6, 1'b0, 1'b0},
      {4'h6, 4'h0, 4'h0, 4'h3, 1'b0, 1'b0},
      {4'h6, 4'h0, 4'h0, 4'h1, 1'b1, 1'b0},
      {4'h6, 4'h0, 4'h0, 4'h8, 1'b1, 1'b0},
      {4'h1, 4'h0, 4'h7, 4'h0, 1'b1, 1'b0},
      {4'hF, 4'h5, 4'h5, 4'h0, 1'b1, 1'b0},
      {4'h1, 4'h0, 4'hF, 4'h0, 1'b1, 1'b0},
      {4'h1, 4'h0, 4'h0, 4'h1, 1'b0, 1'b0}
   };

   function automatic string req_of(logic [3:0] op);
      case (op)
         4'h1: return "R2";
         4'h2: return "R3";
         4'h3: return "R4";
         4'h4, 4'h5: return "R5";
         4'h6: return "R6";
         4'h7, 4'h8: return "R7";
         4'hE: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic step(logic [3:0] op, logic [3:0] imm, logic [3:0] mem);
      @(negedge clk);
      op_i  = op;
      imm_i = imm;
      mem_i = mem;
      @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #2_000_000;
      checks++;
      failures++;
      $display("FAIL R12 watchdog act=running exp=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk("R1 acc", acc_o, 0);
      chk("R1 cy", cy_o, 0);
      chk("R1 b", b_o, 0);
      chk("R1 e", e_o, 0);
      chk("R1 d", d_o, 0);
      chk("R1 skip", skip_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][17:14], VEC[i][13:10], VEC[i][9:6]);
         chk({req_of(VEC[i][17:14]), " acc"}, acc_o, VEC[i][5:2]);
         chk({req_of(VEC[i][17:14]), " cy"}, cy_o, VEC[i][1]);
         chk({req_of(VEC[i][17:14]), " skip"}, skip_o, VEC[i][0]);
      end

      // R8: accumulator to scratch and back
      step(4'hE, 4'h5, 4'h0);
      step(4'h9, 4'h0, 4'h0);
      chk("R8 a2b", b_o, 4'h5);
      step(4'hE, 4'hA, 4'h0);
      step(4'hB, 4'h0, 4'h0);
      // R9: byte register from scratch:accumulator
      chk("R9 ba2e", e_o, 8'h5A);
      step(4'hE, 4'h3, 4'h0);
      step(4'hA, 4'h0, 4'h0);
      chk("R8 b2a", acc_o, 4'h5);
      step(4'hE, 4'h0, 4'h0);
      step(4'h9, 4'h0, 4'h0);
      step(4'hC, 4'h0, 4'h0);
      chk("R9 e2ba b", b_o, 4'h5);
      chk("R9 e2ba a", acc_o, 4'hA);
      // R10: page pointer takes low 3 bits of the immediate
      step(4'hD, 4'hE, 4'h0);
      chk("R10 ldd", d_o, 3'h6);
      // R11: table address from page pointer and accumulator
      chk("R11 tab", tab_addr_o, 7'h6A);
      step(4'hE, 4'h3, 4'h0);
      chk("R11 tab follows acc", tab_addr_o, 7'h63);
      // R12: idle opcodes touch nothing
      step(4'h7, 4'h0, 4'h0);
      step(4'h0, 4'hF, 4'hF);
      step(4'hF, 4'hF, 4'hF);
      chk("R12 acc", acc_o, 4'h3);
      chk("R12 cy", cy_o, 1);
      chk("R12 b", b_o, 4'h5);
      chk("R12 e", e_o, 8'h5A);
      chk("R12 d", d_o, 3'h6);
      chk("R12 skip", skip_o, 0);
      // R1: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      chk("R1 rerun acc", acc_o, 0);
      chk("R1 rerun cy", cy_o, 0);
      chk("R1 rerun e", e_o, 0);
      chk("R1 rerun tab", tab_addr_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R4: overflowing add immediate right after reset
      step(4'hE, 4'hF, 4'h0);
      step(4'h3, 4'h1, 4'h0);
      chk("R4 skip wrap", skip_o, 1);
      chk("R4 acc wrap", acc_o, 0);
      chk("R4 cy kept", cy_o, 0);
      step(4'h0, 4'h0, 4'h0);
      chk("R4 skip one cycle", skip_o, 0);
      finish_run();
   end

endmodule